// File: doc/BRIEF.md
# External Interrupt Request Flag Bank

This block holds one latched request flag for each of up to sixteen external interrupt lines. Each raw line is first resynchronized to the core clock. A detector then watches for the event chosen for that line: a low level, a falling edge, a rising edge or either edge. A flag, once set, stays set until it is cleared. The flag vector serves as the read data of a software register. A per-line enable input masks each flag onto a request output for a downstream priority arbiter.

Software clears a flag with a two-step handshake. It first reads the flag while it is 1, which arms that bit. A later write of 0 to that bit then clears it. Writing 1 never changes a flag. Two hardware strobes can also clear a flag. The first is the acknowledge of interrupt exception handling for a line. The second is the activation of a data transfer controller by a line, unless that transfer asks to keep the flag. For a line in low-level mode, an acknowledge clears the flag only while the synchronized input is high again. A parameter can leave the upper eight lines unimplemented.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset every flag and every request output is 0.
- R2: Line n uses the two bits det_mode[2n+1:2n] to choose its event: 00 = input low, 01 = falling edge, 10 = rising edge, 11 = either edge. Inputs idle high after reset. A change on an input shows up in its flag after the third rising clock edge: two synchronizer stages, then the flag register.
- R3: When wr_en is asserted, a bit of wr_data that is 1 leaves the matching flag unchanged.
- R4: A cycle with rd_en arms every bit whose flag is 1 in that cycle. In a later cycle, wr_en with wr_data bit n = 0 clears flag n only if bit n is armed. Any clear of a flag disarms its bit. Reading a bit while it is 0 does not arm it.
- R5: When ack_valid is asserted with ack_line = n, and line n is in an edge mode (01, 10 or 11), flag n clears on that clock edge.
- R6: When ack_valid is asserted with ack_line = n, and line n is in low-level mode (00), flag n clears only if input n, as seen after the synchronizer, is high.
- R7: When xfer_valid is asserted with xfer_line = n, flag n clears if xfer_keep is 0. If xfer_keep is 1, the flag is left unchanged.
- R8: With IMPL_LINES = 8, flags 8 to 15 and their request outputs are always 0, whatever the inputs.
- R9: When a detected event and any clear reach the same line in the same cycle, the flag is 1 after that edge. A low-level line whose input stays low therefore cannot be cleared.
- R10: req_o bit n is 1 exactly when flag n is 1 and line_en bit n is 1. This is a combinational path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | Raw external request lines, asynchronous |
| det_mode | input | 2*NUM_LINES | Detection mode, two bits per line |
| line_en | input | NUM_LINES | Per-line request enable |
| rd_en | input | 1 | Register read strobe, arms flags that read 1 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | NUM_LINES | Write data, 0 bits request a clear |
| ack_valid | input | 1 | Exception handling acknowledge strobe |
| ack_line | input | LINE_W | Line being acknowledged |
| xfer_valid | input | 1 | Transfer controller activation strobe |
| xfer_line | input | LINE_W | Line that activated the transfer |
| xfer_keep | input | 1 | 1 = leave the flag set after the activation |
| flag_o | output | NUM_LINES | Flag vector, also the register read data |
| req_o | output | NUM_LINES | Flags masked by line_en |

## Verification
A table of vectors drives line 0 through an idle-high start, then two further input levels, in each of the four modes. This shows that a level mode tracks an input that stays low, and that each edge mode responds only to its own transition direction. One line checks the three-edge latency, so an extra or missing synchronizer stage is caught. Directed sequences then separate armed from unarmed writes, edge-mode acknowledges from level-mode acknowledges (with the input low and then high), and transfer activations with xfer_keep set and clear. A new event that coincides with a clear shows that the set wins. A second instance with eight implemented lines shows that the upper bits stay 0.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    typedef enum logic [1:0] {
        DET_LOW  = 2'b00,
        DET_FALL = 2'b01,
        DET_RISE = 2'b10,
        DET_BOTH = 2'b11
    } det_mode_e;

    function automatic logic line_event(input logic [1:0] mode,
                                        input logic       cur,
                                        input logic       prev);
        logic hit;
        case (det_mode_e'(mode))
            DET_LOW:  hit = ~cur;
            DET_FALL: hit = prev & ~cur;
            DET_RISE: hit = ~prev & cur;
            default:  hit = prev ^ cur;
        endcase
        return hit;
    endfunction

    function automatic logic is_level(input logic [1:0] mode);
        return det_mode_e'(mode) == DET_LOW;
    endfunction

endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stg[s] = st_q.stg[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.stg[STAGES-1];
endmodule

// File: rtl/irq_event_detect.sv
module irq_event_detect
    import irq_flag_pkg::*;
#(
    parameter int NUM_LINES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   sync_in,
    input  logic [2*NUM_LINES-1:0] det_mode,
    output logic [NUM_LINES-1:0]   evt_o
);
    typedef struct packed {
        logic [NUM_LINES-1:0] prev;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        assign evt_o[n] = line_event(det_mode[2*n +: 2], sync_in[n], st_q.prev[n]);
    end
endmodule

// File: rtl/irq_flag_core.sv
module irq_flag_core
    import irq_flag_pkg::*;
#(
    parameter int NUM_LINES  = 16,
    parameter int IMPL_LINES = 16,
    parameter int LINE_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   evt,
    input  logic [NUM_LINES-1:0]   sync_lvl,
    input  logic [2*NUM_LINES-1:0] det_mode,
    input  logic                   rd_en,
    input  logic                   wr_en,
    input  logic [NUM_LINES-1:0]   wr_data,
    input  logic                   ack_valid,
    input  logic [LINE_W-1:0]      ack_line,
    input  logic                   xfer_valid,
    input  logic [LINE_W-1:0]      xfer_line,
    input  logic                   xfer_keep,
    output logic [NUM_LINES-1:0]   flag_o
);
    localparam logic [NUM_LINES-1:0] IMPL_MASK =
        (IMPL_LINES >= NUM_LINES) ? '1 : ((NUM_LINES'(1) << IMPL_LINES) - NUM_LINES'(1));

    typedef struct packed {
        logic [NUM_LINES-1:0] flag;
        logic [NUM_LINES-1:0] arm;
    } core_t;

    core_t st_d, st_q;

    logic [NUM_LINES-1:0] ack_clr, xfer_clr, sw_clr, clr_any;

    always_comb begin
        ack_clr  = '0;
        xfer_clr = '0;
        for (int n = 0; n < NUM_LINES; n++) begin
            if (ack_valid && ack_line == LINE_W'(n)) begin
                ack_clr[n] = !is_level(det_mode[2*n +: 2]) || sync_lvl[n];
            end
            if (xfer_valid && xfer_line == LINE_W'(n)) begin
                xfer_clr[n] = !xfer_keep;
            end
        end
        sw_clr  = wr_en ? (~wr_data & st_q.arm) : '0;
        clr_any = ack_clr | xfer_clr | sw_clr;

        st_d      = st_q;
        st_d.flag = ((st_q.flag & ~clr_any) | evt) & IMPL_MASK;
        st_d.arm  = (st_q.arm | (rd_en ? st_q.flag : '0)) & ~clr_any & st_d.flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_flag_pkg::*;
#(
    parameter int NUM_LINES   = 16,
    parameter int IMPL_LINES  = 16,
    parameter int SYNC_STAGES = 2,
    parameter int LINE_W      = $clog2(NUM_LINES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   irq_in,
    input  logic [2*NUM_LINES-1:0] det_mode,
    input  logic [NUM_LINES-1:0]   line_en,
    input  logic                   rd_en,
    input  logic                   wr_en,
    input  logic [NUM_LINES-1:0]   wr_data,
    input  logic                   ack_valid,
    input  logic [LINE_W-1:0]      ack_line,
    input  logic                   xfer_valid,
    input  logic [LINE_W-1:0]      xfer_line,
    input  logic                   xfer_keep,
    output logic [NUM_LINES-1:0]   flag_o,
    output logic [NUM_LINES-1:0]   req_o
);
    logic [NUM_LINES-1:0] sync_lvl;
    logic [NUM_LINES-1:0] line_evt;

    irq_sync_bank #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (irq_in),
        .dout (sync_lvl)
    );

    irq_event_detect #(.NUM_LINES(NUM_LINES)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_lvl),
        .det_mode(det_mode),
        .evt_o   (line_evt)
    );

    irq_flag_core #(.NUM_LINES(NUM_LINES), .IMPL_LINES(IMPL_LINES), .LINE_W(LINE_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (line_evt),
        .sync_lvl  (sync_lvl),
        .det_mode  (det_mode),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ack_valid (ack_valid),
        .ack_line  (ack_line),
        .xfer_valid(xfer_valid),
        .xfer_line (xfer_line),
        .xfer_keep (xfer_keep),
        .flag_o    (flag_o)
    );

    assign req_o = flag_o & line_en;
endmodule

// File: rtl/irq_flag_bank_chk.sv
module irq_flag_bank_chk #(
    parameter int NUM_LINES  = 16,
    parameter int IMPL_LINES = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] flag_o,
    input logic [NUM_LINES-1:0] req_o,
    input logic [NUM_LINES-1:0] line_en,
    input logic [NUM_LINES-1:0] line_evt,
    input logic                 wr_en,
    input logic [NUM_LINES-1:0] wr_data,
    input logic                 ack_valid,
    input logic                 xfer_valid
);
    localparam logic [NUM_LINES-1:0] IMPL_MASK =
        (IMPL_LINES >= NUM_LINES) ? '1 : ((NUM_LINES'(1) << IMPL_LINES) - NUM_LINES'(1));

    p_write_one_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (&wr_data) && !ack_valid && !xfer_valid)
        |=> (($past(flag_o) & ~flag_o) == '0));

    p_clear_needs_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flag_o) & ~flag_o) != '0) |-> $past(wr_en || ack_valid || xfer_valid));

    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_o & ~IMPL_MASK) == '0) && ((req_o & ~IMPL_MASK) == '0));

    p_event_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_evt & IMPL_MASK) != '0) |=> ((flag_o & $past(line_evt & IMPL_MASK)) == $past(line_evt & IMPL_MASK)));

    p_req_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_o & ~flag_o) == '0) && ((req_o & ~line_en) == '0));
endmodule

bind irq_flag_bank irq_flag_bank_chk #(.NUM_LINES(NUM_LINES), .IMPL_LINES(IMPL_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_o    (flag_o),
    .req_o     (req_o),
    .line_en   (line_en),
    .line_evt  (line_evt),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ack_valid (ack_valid),
    .xfer_valid(xfer_valid)
);

// File: tb/irq_flag_bank_tb.sv
module irq_flag_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    // row: {mode[1:0], first level, second level, expected flag0}
    localparam logic [4:0] VEC [0:10] = '{
        5'b00_1_1_0, 5'b00_1_0_1,
        5'b01_1_0_1, 5'b01_1_1_0, 5'b01_0_1_1,
        5'b10_1_0_0, 5'b10_0_1_1, 5'b10_1_1_0,
        5'b11_1_0_1, 5'b11_1_1_0, 5'b11_0_1_1
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]   irq_in   = '1;
    logic [2*N-1:0] det_mode = {N{2'b01}};
    logic [N-1:0]   line_en  = '1;
    logic rd_en = 1'b0, wr_en = 1'b0, ack_valid = 1'b0, xfer_valid = 1'b0, xfer_keep = 1'b0;
    logic [N-1:0] wr_data = '1;
    logic [3:0] ack_line = '0, xfer_line = '0;
    logic [N-1:0] flag_o, req_o, flag_h, req_h;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_bank #(.NUM_LINES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .det_mode(det_mode), .line_en(line_en),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .ack_valid(ack_valid),
        .ack_line(ack_line), .xfer_valid(xfer_valid), .xfer_line(xfer_line),
        .xfer_keep(xfer_keep), .flag_o(flag_o), .req_o(req_o)
    );

    irq_flag_bank #(.NUM_LINES(N), .IMPL_LINES(8)) u_dut_half (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .det_mode(det_mode), .line_en(line_en),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .ack_valid(ack_valid),
        .ack_line(ack_line), .xfer_valid(xfer_valid), .xfer_line(xfer_line),
        .xfer_keep(xfer_keep), .flag_o(flag_h), .req_o(req_h)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic sw_read();
        rd_en = 1'b1; tick(1); rd_en = 1'b0;
    endtask

    task automatic sw_write(input logic [N-1:0] d);
        wr_en = 1'b1; wr_data = d; tick(1); wr_en = 1'b0; wr_data = '1;
    endtask

    task automatic ack(input int line);
        ack_valid = 1'b1; ack_line = 4'(line); tick(1); ack_valid = 1'b0;
    endtask

    task automatic xfer(input int line, input logic keep);
        xfer_valid = 1'b1; xfer_line = 4'(line); xfer_keep = keep; tick(1);
        xfer_valid = 1'b0; xfer_keep = 1'b0;
    endtask

    // pulse line low and back high (falling edge mode sets the flag)
    task automatic pulse_low(input int line);
        irq_in[line] = 1'b0; tick(4); irq_in[line] = 1'b1; tick(4);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        do_reset();
        check("R1 flags after reset", 32'(flag_o), 32'h0);
        check("R1 requests after reset", 32'(req_o), 32'h0);

        // R2 table walk on line 0
        for (int i = 0; i < 11; i++) begin
            det_mode[1:0] = VEC[i][4:3];
            do_reset();
            irq_in[0] = VEC[i][2]; tick(4);
            irq_in[0] = VEC[i][1]; tick(4);
            check($sformatf("R2 vector %0d flag0", i), 32'(flag_o[0]), 32'(VEC[i][0]));
            irq_in[0] = 1'b1;
            det_mode[1:0] = 2'b01;
        end

        // R2 latency: third edge
        do_reset();
        irq_in[2] = 1'b0; tick(2);
        check("R2 flag2 not yet after two edges", 32'(flag_o[2]), 32'h0);
        tick(1);
        check("R2 flag2 after third edge", 32'(flag_o[2]), 32'h1);
        irq_in[2] = 1'b1; tick(3);

        // R10 enable masking
        pulse_low(3);
        line_en[3] = 1'b0; #1;
        check("R10 masked request", 32'(req_o[3]), 32'h0);
        line_en[3] = 1'b1; #1;
        check("R10 enabled request", 32'(req_o[3]), 32'h1);

        // R4 write 0 without prior read
        sw_write(~(16'h1 << 3));
        check("R4 unarmed write keeps flag3", 32'(flag_o[3]), 32'h1);
        // R3 write ones after read
        sw_read();
        sw_write('1);
        check("R3 write ones keeps flags", 32'(flag_o), 32'h0000_000C);
        // R4 armed clear
        sw_write(~(16'h1 << 3));
        check("R4 armed write clears flag3", 32'(flag_o[3]), 32'h0);
        check("R4 other armed flag2 kept by its 1 bit", 32'(flag_o[2]), 32'h1);
        // R4 read while 0 does not arm
        sw_read();
        pulse_low(3);
        sw_write(~(16'h1 << 3));
        check("R4 read of 0 does not arm", 32'(flag_o[3]), 32'h1);

        // R5 edge-mode acknowledge
        pulse_low(5);
        ack(5);
        check("R5 ack clears edge flag5", 32'(flag_o[5]), 32'h0);

        // R6 level-mode acknowledge
        det_mode[13:12] = 2'b00;
        irq_in[6] = 1'b0; tick(4);
        ack(6);
        check("R6 ack with input low keeps flag6", 32'(flag_o[6]), 32'h1);
        irq_in[6] = 1'b1; tick(3);
        ack(6);
        check("R6 ack with input high clears flag6", 32'(flag_o[6]), 32'h0);
        det_mode[13:12] = 2'b01;

        // R7 transfer activation
        pulse_low(7);
        xfer(7, 1'b1);
        check("R7 keep set leaves flag7", 32'(flag_o[7]), 32'h1);
        xfer(7, 1'b0);
        check("R7 keep clear clears flag7", 32'(flag_o[7]), 32'h0);

        // R9 level low beats armed software clear
        det_mode[17:16] = 2'b00;
        irq_in[8] = 1'b0; tick(4);
        sw_read();
        sw_write(~(16'h1 << 8));
        check("R9 level low survives clear", 32'(flag_o[8]), 32'h1);
        irq_in[8] = 1'b1; det_mode[17:16] = 2'b01; tick(3);

        // R9 new edge coincides with transfer clear
        pulse_low(9);
        irq_in[9] = 1'b0; tick(2);
        xfer(9, 1'b0);
        check("R9 set wins over coincident clear", 32'(flag_o[9]), 32'h1);
        irq_in[9] = 1'b1; tick(3);

        // R8 reduced configuration
        do_reset();
        irq_in = '0; tick(4);
        check("R8 half instance upper flags zero", 32'(flag_h), 32'h0000_00FF);
        check("R8 half instance upper requests zero", 32'(req_h), 32'h0000_00FF);
        check("R2 full instance all lines set", 32'(flag_o), 32'h0000_FFFF);
        irq_in = '1; tick(3);

        report();
    end
endmodule